// File: doc/BRIEF.md
# Triangular Dither PWM Oversampler

This block is the digital half of a dithered oversampling converter front end. On each window-start tick it opens a window of 2^p conversions. During the window it drives a PWM output, and the PWM duty follows a triangle of precomputed compare values. An external RC network and summing amplifier turn that duty into a small triangular dither that is added to the analog input. The compare value moves one step for each accepted conversion, so the dither stays in lock-step with the sample stream. The whole triangle spans one window.

When the last conversion of the window arrives, the block adds the 2^p samples and subtracts a programmed offset, which cancels the bias of the inverting summing stage. It then presents the estimate with one valid pulse. Each doubling of the window adds one bit of resolution. The limit of 4 extra bits follows from a 56-cycle PWM period, because the duty steps must stay coarse enough for the timer to resolve them. A tick that arrives while a window is still open is flagged as an overrun, and that window is dropped.

Top module: `dither_oversampler`

## Requirements
- R1: After reset `res_valid`, `overrun` and `pwm_out` are 0, and no window is open.
- R2: A window opened with effective extra-bit count p closes on its 2^p-th accepted sample. `res_valid` is high for exactly the one cycle after the clock edge that takes that sample, and it stays low earlier in the window.
- R3: `res_data` equals the sum of the window's 2^p samples minus `offset`, taken modulo 2^16. The `offset` value used is the one present in the closing cycle.
- R4: A value of `extra_bits` above 4 (the codes 5, 6 and 7) is treated as 4, which gives 16 samples per window.
- R5: `extra_bits` is captured on the window-start tick. A change to it while the window is open has no effect on that window's length or result.
- R6: A sample is ignored when no window is open, and also when it arrives in the same cycle as a tick. An ignored sample produces no result and does not enter any later sum.
- R7: While a window is open, the PWM repeats with a period of 56 clock cycles and is high for exactly C cycles of each period, where C is the current compare value. `pwm_out` is 0 while no window is open.
- R8: The compare value for step k of a window with OSR = 2^p is floor(min(k, OSR-k) * 55 / (OSR/2)) for p ≥ 1, and 0 for p = 0. The step is 0 on opening and advances by one on each accepted sample.
- R9: A tick while a window is open pulses `overrun` for one cycle. No result is produced for the abandoned window, and a new window starts from that tick. This also applies when the tick coincides with the window's closing sample.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| win_start | input | 1 | Window-start tick |
| extra_bits | input | 3 | Requested extra resolution bits p |
| offset | input | 16 | Value subtracted from the window sum |
| smp_valid | input | 1 | Conversion result valid |
| smp_data | input | 12 | Conversion result |
| pwm_out | output | 1 | Dither PWM output |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 16 | Offset-corrected window sum |
| overrun | output | 1 | One-cycle overrun strobe |

## Verification
If the sample counter or the captured extra-bit count drifts, the result strobe moves away from the 2^p-th sample, and this shows in the same window. If the accumulator is corrupted, `res_data` is wrong on that strobe. If the step index or the compare table is wrong, the number of high cycles in a 56-cycle stretch of `pwm_out` is wrong, which shows within one PWM period after the step changes. Overrun handling is checked at the ports: the bench looks at the strobe, confirms that no result is produced, and checks that the next sum holds only the fresh samples.

// File: rtl/dither_ovs_pkg.sv
package dither_ovs_pkg;

   typedef enum logic {
      WIN_IDLE = 1'b0,
      WIN_OPEN = 1'b1
   } win_state_e;

   // Triangle compare value for step idx of a 2^pexp window, peak = top
   function automatic int tri_step(input int idx, input int pexp, input int top);
      int osr;
      int half;
      int fold;
      if (pexp == 0) return 0;
      osr  = 1 << pexp;
      half = osr / 2;
      fold = (idx <= half) ? idx : (osr - idx);
      return (fold * top) / half;
   endfunction

endpackage

// File: rtl/dither_ovs_window.sv
module dither_ovs_window
   import dither_ovs_pkg::*;
#(
   parameter int SMP_W     = 12,
   parameter int MAX_EXTRA = 4,
   parameter int PW_W      = 3,
   parameter int CNT_W     = 4,
   parameter int RES_W     = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_start,
   input  logic [PW_W-1:0]  extra_bits,
   input  logic [RES_W-1:0] offset,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             active,
   output logic [PW_W-1:0]  p_eff,
   output logic [CNT_W-1:0] step,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             overrun
);

   win_state_e       state_q;
   logic [PW_W-1:0]  p_q;
   logic [CNT_W-1:0] idx_q;
   logic [RES_W-1:0] sum_q;
   logic [PW_W-1:0]  p_clamped;
   logic [CNT_W:0]   osr_full;
   logic [CNT_W-1:0] last_idx;
   logic [RES_W-1:0] sum_next;
   logic             take;

   assign p_clamped = (extra_bits > PW_W'(MAX_EXTRA)) ? PW_W'(MAX_EXTRA) : extra_bits;
   assign osr_full  = (CNT_W+1)'(1) << p_q;
   assign last_idx  = CNT_W'(osr_full - (CNT_W+1)'(1));
   assign sum_next  = sum_q + RES_W'(smp_data);
   assign take      = (state_q == WIN_OPEN) && smp_valid && !win_start;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= WIN_IDLE;
         p_q       <= '0;
         idx_q     <= '0;
         sum_q     <= '0;
         res_valid <= 1'b0;
         res_data  <= '0;
         overrun   <= 1'b0;
      end else begin
         res_valid <= 1'b0;
         overrun   <= 1'b0;
         if (win_start) begin
            overrun <= (state_q == WIN_OPEN);
            state_q <= WIN_OPEN;
            p_q     <= p_clamped;
            idx_q   <= '0;
            sum_q   <= '0;
         end else if (take) begin
            if (idx_q == last_idx) begin
               state_q   <= WIN_IDLE;
               res_valid <= 1'b1;
               res_data  <= sum_next - offset;
               idx_q     <= '0;
               sum_q     <= '0;
            end else begin
               idx_q <= idx_q + CNT_W'(1);
               sum_q <= sum_next;
            end
         end
      end
   end

   assign active = (state_q == WIN_OPEN);
   assign p_eff  = p_q;
   assign step   = idx_q;

endmodule

// File: rtl/dither_ovs_tri_rom.sv
module dither_ovs_tri_rom
   import dither_ovs_pkg::*;
#(
   parameter int MAX_EXTRA = 4,
   parameter int TOP       = 55,
   parameter int CW        = 6,
   parameter int PW_W      = 3,
   parameter int CNT_W     = 4
) (
   input  logic [PW_W-1:0]  p_sel,
   input  logic [CNT_W-1:0] idx,
   output logic [CW-1:0]    cmp
);

   localparam int DEPTH = 1 << MAX_EXTRA;

   logic [CW-1:0] tbl [MAX_EXTRA+1][DEPTH];

   for (genvar gp = 0; gp <= MAX_EXTRA; gp++) begin : g_exp
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_ent
         localparam int VAL = (gi < (1 << gp)) ? tri_step(gi, gp, TOP) : 0;
         assign tbl[gp][gi] = CW'(VAL);
      end
   end

   assign cmp = tbl[p_sel][idx];

endmodule

// File: rtl/dither_ovs_pwm.sv
module dither_ovs_pwm #(
   parameter int PERIOD = 56,
   parameter int CW     = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          restart,
   input  logic          active,
   input  logic [CW-1:0] cmp,
   output logic [CW-1:0] cnt,
   output logic          pwm
);

   localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (restart || !active) begin
         cnt_q <= '0;
      end else if (cnt_q == LAST) begin
         cnt_q <= '0;
      end else begin
         cnt_q <= cnt_q + CW'(1);
      end
   end

   assign cnt = cnt_q;
   assign pwm = active && (cnt_q < cmp);

endmodule

// File: rtl/dither_oversampler.sv
module dither_oversampler #(
   parameter int SMP_W      = 12,
   parameter int MAX_EXTRA  = 4,
   parameter int PWM_PERIOD = 56,
   localparam int PW_W      = $clog2(MAX_EXTRA + 1),
   localparam int RES_W     = SMP_W + MAX_EXTRA
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             win_start,
   input  logic [PW_W-1:0]  extra_bits,
   input  logic [RES_W-1:0] offset,
   input  logic             smp_valid,
   input  logic [SMP_W-1:0] smp_data,
   output logic             pwm_out,
   output logic             res_valid,
   output logic [RES_W-1:0] res_data,
   output logic             overrun
);

   localparam int CNT_W = MAX_EXTRA;
   localparam int CW    = $clog2(PWM_PERIOD);
   localparam int TOP   = PWM_PERIOD - 1;

   if (MAX_EXTRA < 1) begin : g_chk_extra
      $error("MAX_EXTRA must be at least 1");
   end
   if ((1 << MAX_EXTRA) > PWM_PERIOD / 2) begin : g_chk_period
      $error("PWM_PERIOD too short for 2^MAX_EXTRA dither steps");
   end
   if (SMP_W < 1) begin : g_chk_smp
      $error("SMP_W must be positive");
   end

   logic             win_active;
   logic [PW_W-1:0]  p_eff;
   logic [CNT_W-1:0] step_idx;
   logic [CW-1:0]    cmp_val;
   logic [CW-1:0]    pwm_cnt;

   dither_ovs_window #(
      .SMP_W(SMP_W), .MAX_EXTRA(MAX_EXTRA), .PW_W(PW_W),
      .CNT_W(CNT_W), .RES_W(RES_W)
   ) u_win (
      .clk(clk), .rst_n(rst_n), .win_start(win_start),
      .extra_bits(extra_bits), .offset(offset),
      .smp_valid(smp_valid), .smp_data(smp_data),
      .active(win_active), .p_eff(p_eff), .step(step_idx),
      .res_valid(res_valid), .res_data(res_data), .overrun(overrun)
   );

   dither_ovs_tri_rom #(
      .MAX_EXTRA(MAX_EXTRA), .TOP(TOP), .CW(CW), .PW_W(PW_W), .CNT_W(CNT_W)
   ) u_rom (
      .p_sel(p_eff), .idx(step_idx), .cmp(cmp_val)
   );

   dither_ovs_pwm #(
      .PERIOD(PWM_PERIOD), .CW(CW)
   ) u_pwm (
      .clk(clk), .rst_n(rst_n), .restart(win_start), .active(win_active),
      .cmp(cmp_val), .cnt(pwm_cnt), .pwm(pwm_out)
   );

endmodule

// File: rtl/dither_oversampler_chk.sv
module dither_oversampler_chk #(
   parameter int PWM_PERIOD = 56,
   parameter int PW_W       = 3,
   parameter int CW         = 6
) (
   input logic            clk,
   input logic            rst_n,
   input logic            win_start,
   input logic            smp_valid,
   input logic            pwm_out,
   input logic            res_valid,
   input logic            overrun,
   input logic            active,
   input logic [PW_W-1:0] p_eff,
   input logic [CW-1:0]   pcnt,
   input logic [CW-1:0]   cmp
);

   a_r2_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      res_valid |=> !res_valid);

   a_r2_after_sample: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(res_valid) |-> $past(smp_valid));

   a_r5_p_held: assert property (@(posedge clk) disable iff (!rst_n)
      (active && !win_start) |=> $stable(p_eff));

   a_r7_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
      !active |-> !pwm_out);

   a_r7_cnt_range: assert property (@(posedge clk) disable iff (!rst_n)
      pcnt < CW'(PWM_PERIOD));

   a_r8_cmp_range: assert property (@(posedge clk) disable iff (!rst_n)
      cmp < CW'(PWM_PERIOD));

   a_r9_overrun_flag: assert property (@(posedge clk) disable iff (!rst_n)
      (win_start && active) |=> (overrun && !res_valid));

   a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
      !(overrun && res_valid));

endmodule

bind dither_oversampler dither_oversampler_chk #(
   .PWM_PERIOD(PWM_PERIOD), .PW_W(PW_W), .CW(CW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .win_start(win_start), .smp_valid(smp_valid),
   .pwm_out(pwm_out), .res_valid(res_valid), .overrun(overrun),
   .active(win_active), .p_eff(p_eff), .pcnt(pwm_cnt), .cmp(cmp_val)
);

// File: tb/dither_oversampler_tb.sv
module dither_oversampler_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        win_start = 1'b0;
   logic [2:0]  extra_bits = '0;
   logic [15:0] offset = '0;
   logic        smp_valid = 1'b0;
   logic [11:0] smp_data = '0;
   logic        pwm_out;
   logic        res_valid;
   logic [15:0] res_data;
   logic        overrun;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   dither_oversampler u_dut (
      .clk(clk), .rst_n(rst_n), .win_start(win_start), .extra_bits(extra_bits),
      .offset(offset), .smp_valid(smp_valid), .smp_data(smp_data),
      .pwm_out(pwm_out), .res_valid(res_valid), .res_data(res_data),
      .overrun(overrun)
   );

   task automatic check(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   function automatic int exp_duty(input int k, input int p);
      int osr;
      int h;
      int f;
      if (p == 0) return 0;
      osr = 1 << p;
      h = osr / 2;
      f = (k < osr - k) ? k : osr - k;
      return (f * 55) / h;
   endfunction

   function automatic int smp_val(input int base, input int stride, input int i);
      return (base + i * stride) % 4096;
   endfunction

   task automatic tick(input int p, input bit with_sample);
      extra_bits = 3'(p);
      win_start  = 1'b1;
      smp_valid  = with_sample;
      smp_data   = 12'hFFF;
      @(negedge clk);
      win_start  = 1'b0;
      smp_valid  = 1'b0;
   endtask

   task automatic send(input int d);
      smp_valid = 1'b1;
      smp_data  = 12'(d);
      @(negedge clk);
      smp_valid = 1'b0;
   endtask

   task automatic count_high(output int hi);
      hi = 0;
      for (int c = 0; c < 56; c++) begin
         if (pwm_out) hi++;
         @(negedge clk);
      end
   endtask

   // R2 R3 R4 R5 R6: one full window
   task automatic run_window(input int p_drive, input int p_eff, input int p_mid,
                             input int base, input int stride, input int off,
                             input bit idle_junk, input string tag);
      int n;
      int sum;
      bit early;
      n = 1 << p_eff;
      sum = 0;
      early = 0;
      if (idle_junk) begin
         for (int j = 0; j < 3; j++) begin
            send(4000);
            if (res_valid || overrun) early = 1;
         end
      end
      tick(p_drive, idle_junk);
      if (p_mid >= 0) extra_bits = 3'(p_mid);
      offset = 16'(off);
      for (int i = 0; i < n; i++) begin
         send(smp_val(base, stride, i));
         sum += smp_val(base, stride, i);
         if (i < n - 1 && res_valid) early = 1;
         if (i < n - 1 && ($urandom_range(0, 1) == 1)) @(negedge clk);
      end
      check({tag, " R2 strobe on last sample"}, int'(res_valid), 1);
      check({tag, " R3 result"}, int'(res_data), (sum - off) & 16'hFFFF);
      check({tag, " R2 R6 no early or stray strobe"}, int'(early), 0);
      @(negedge clk);
      check({tag, " R2 single cycle strobe"}, int'(res_valid), 0);
   endtask

   task automatic t_reset();
      check("R1 res_valid after reset", int'(res_valid), 0);
      check("R1 overrun after reset", int'(overrun), 0);
      check("R1 pwm after reset", int'(pwm_out), 0);
   endtask

   task automatic t_pwm(input int p, input string tag);
      int hi;
      int n;
      n = 1 << p;
      tick(p, 1'b0);
      count_high(hi);
      check({tag, " R8 step 0 duty"}, hi, exp_duty(0, p));
      for (int k = 1; k < n; k++) begin
         send(100);
         if (k == 1 || k == n / 2 || k == (3 * n) / 4 || k == n - 1) begin
            count_high(hi);
            check({tag, " R7 R8 duty per period"}, hi, exp_duty(k, p));
         end
      end
      send(100);
      check({tag, " R2 window closes"}, int'(res_valid), 1);
      count_high(hi);
      check({tag, " R7 idle pwm low"}, hi, 0);
   endtask

   task automatic t_overrun(input bit on_close);
      int sum;
      offset = 16'd0;
      tick(2, 1'b0);
      for (int i = 0; i < 3; i++) send(1000);
      if (on_close) begin
         win_start = 1'b1;
         smp_valid = 1'b1;
         smp_data  = 12'd1000;
         @(negedge clk);
         win_start = 1'b0;
         smp_valid = 1'b0;
      end else begin
         tick(2, 1'b0);
      end
      check("R9 overrun strobe", int'(overrun), 1);
      check("R9 no result for dropped window", int'(res_valid), 0);
      @(negedge clk);
      check("R9 overrun single cycle", int'(overrun), 0);
      sum = 0;
      for (int i = 0; i < 4; i++) begin
         send(10 + i);
         sum += 10 + i;
      end
      check("R9 fresh window result", int'(res_data), sum);
      check("R9 fresh window strobe", int'(res_valid), 1);
      @(negedge clk);
   endtask

   initial begin
      #(8 * 150000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      run_window(0, 0, -1, 77, 0, 5, 1'b0, "p0");
      run_window(1, 1, -1, 4095, 0, 0, 1'b0, "p1");
      run_window(2, 2, -1, 100, 37, 300, 1'b0, "p2");
      run_window(3, 3, -1, 2000, 611, 1234, 1'b0, "p3");
      run_window(4, 4, -1, 4095, 0, 0, 1'b0, "p4 max");
      run_window(2, 2, -1, 5, 1, 1000, 1'b0, "R3 wrap");
      run_window(7, 4, -1, 33, 250, 17, 1'b0, "R4 clamp7");
      run_window(5, 4, -1, 9, 3, 0, 1'b0, "R4 clamp5");
      run_window(2, 2, 4, 300, 41, 2, 1'b0, "R5 change up");
      run_window(4, 4, 1, 12, 129, 9, 1'b0, "R5 change down");
      run_window(2, 2, -1, 50, 7, 0, 1'b1, "R6 ignore");
      t_pwm(4, "p4");
      t_pwm(2, "p2");
      t_pwm(1, "p1");
      t_overrun(1'b0);
      t_overrun(1'b1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule